// File: doc/BRIEF.md
# External status interrupt unit

This unit watches the external and status conditions of one serial channel and raises a single interrupt-pending flag when an enabled condition changes. There are five level conditions: break/abort detected by the receiver, transmit underrun/end-of-message, the CTS pin, the DCD pin, and a shared condition. The shared condition is the SYNC pin in asynchronous mode and the receiver hunt status in synchronous modes. There is also one event condition, a pulse from the baud counter each time it reaches zero.

A CPU writes an 8-bit enable byte through a plain write strobe. It reads back the enable byte and a status byte. The status byte holds the condition levels together with the two buffer flags. When an interrupt is raised, the level part of the status byte is frozen as a snapshot. The CPU reads the snapshot, then issues an external/status reset command. The command releases the snapshot. A change that arrived while the snapshot was frozen raises a new interrupt on the next clock instead of being lost.

Two further enable bits do not act inside the unit and are passed out as flags. One enables the frame status FIFO, and it is gated by SDLC mode. The other grants extended access to the alternate write register.

Top module: `extstat_irq`

## Requirements
- R1: After hardware reset, `en_o` reads 8'hF8, `irq_o` is 0 and, with all condition inputs low, `status_o` is 8'h00.
- R2: A cycle with `wr_en_i` high loads `wr_data_i` into the enable byte. From the next clock on, `en_o` returns the written value, for every 8-bit value.
- R3: The enable bits are: bit 7 break/abort, bit 6 transmit underrun, bit 5 CTS, bit 4 SYNC/hunt, bit 3 DCD, bit 1 zero count. A rising or a falling change of `brk_abort_i` or `tx_undr_i` while its enable is set makes `irq_o` high after one clock edge.
- R4: The pins `cts_pin_i`, `dcd_pin_i` and `sync_pin_i` pass through a SYNC_STAGES-flop synchronizer. With the default of 2, an enabled change of either polarity shows on `irq_o` after exactly three clock edges and not after two.
- R5: When `async_mode_i` is 1, the bit 4 condition is `sync_pin_i` and `hunt_i` has no effect. When it is 0, the bit 4 condition is `hunt_i`, which is taken without a synchronizer, and `sync_pin_i` has no effect.
- R6: A change on a source whose enable bit is 0 never sets `irq_o`.
- R7: The status byte layout is: bit 7 break, bit 6 underrun, bit 5 CTS, bit 4 SYNC/hunt, bit 3 DCD, bit 2 `tx_empty_i`, bit 1 zero-count flag, bit 0 `rx_avail_i`. While `irq_o` is high, bits 7..3 keep the values they held at the clock that raised it.
- R8: `irq_o` stays high until `es_reset_i` is sampled high, and is low after that edge. If any enabled level then differs from the snapshot, `irq_o` goes high again one edge later and the snapshot takes the new levels.
- R9: A `zcount_i` pulse with enable bit 1 set raises status bit 1 after one edge and `irq_o` after two. `es_reset_i` clears both. A pulse with bit 1 clear changes neither.
- R10: A `chan_rst_i` pulse clears `irq_o` and the zero-count flag, and reloads the enable byte with 8'hF8, all at the same edge. It takes priority over a simultaneous write.
- R11: `fifo_en_o` equals enable bit 2 AND `sdlc_mode_i`. `alt_wr_o` equals enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst_i | input | 1 | Channel reset command pulse |
| wr_en_i | input | 1 | Enable byte write strobe |
| wr_data_i | input | 8 | Enable byte write data |
| en_o | output | 8 | Enable byte readback |
| brk_abort_i | input | 1 | Receiver break/abort level |
| tx_undr_i | input | 1 | Transmit underrun/end-of-message level |
| hunt_i | input | 1 | Receiver hunt level |
| cts_pin_i | input | 1 | CTS pin, asynchronous |
| dcd_pin_i | input | 1 | DCD pin, asynchronous |
| sync_pin_i | input | 1 | SYNC pin, asynchronous |
| zcount_i | input | 1 | Baud counter zero pulse |
| async_mode_i | input | 1 | 1 selects asynchronous mode |
| sdlc_mode_i | input | 1 | 1 when SDLC mode is selected |
| es_reset_i | input | 1 | Reset external/status command pulse |
| tx_empty_i | input | 1 | Transmit buffer empty flag |
| rx_avail_i | input | 1 | Receive character available flag |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | External/status interrupt pending |
| fifo_en_o | output | 1 | Frame status FIFO enable, gated by SDLC mode |
| alt_wr_o | output | 1 | Alternate write register access enable |

## Verification
A corrupted snapshot register appears on status bits 7..3 at the first read taken while an interrupt is pending. It also shows one edge after the reset command, as a missing or spurious re-raise of `irq_o`. A wrong pending flag or a lost zero-count flag shows on `irq_o` within one or two edges of the triggering change. A synchronizer of the wrong depth moves the pin-to-interrupt delay off its three-edge slot. An enable byte that loaded or reset wrongly appears on `en_o` at the next clock and changes which sources the sweep finds able to interrupt.

// File: rtl/esi_pkg.sv
package esi_pkg;
   localparam int EN_W = 8;
   localparam int NLVL = 5;
   localparam logic [EN_W-1:0] EN_DEFAULT = 8'hF8;
   // enable / status bit positions
   localparam int B_BRK  = 7;
   localparam int B_TXU  = 6;
   localparam int B_CTS  = 5;
   localparam int B_SH   = 4;
   localparam int B_DCD  = 3;
   localparam int B_FIFO = 2;
   localparam int B_ZC   = 1;
   localparam int B_ALT  = 0;
   localparam int LVL_LO = B_DCD;
   // level vector order {brk, txu, cts, sh, dcd} matches enable bits 7..3
   typedef logic [NLVL-1:0] lvl_t;
   typedef logic [EN_W-1:0] en_t;
endpackage

// File: rtl/esi_sync.sv
module esi_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] pipe [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("esi_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/esi_enreg.sv
module esi_enreg
   import esi_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic chan_rst_i,
   input  logic wr_en_i,
   input  en_t  wr_data_i,
   output en_t  en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q <= EN_DEFAULT;
      else if (chan_rst_i) en_q <= EN_DEFAULT;
      else if (wr_en_i)    en_q <= wr_data_i;
   end

   AST_CHAN_RST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst_i |=> (en_q == EN_DEFAULT)); // R10
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !chan_rst_i) |=> (en_q == $past(wr_data_i))); // R2
endmodule

// File: rtl/esi_detect.sv
module esi_detect
   import esi_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic chan_rst_i,
   input  logic clr_i,
   input  lvl_t live_i,
   input  lvl_t en_lvl_i,
   input  logic zc_pulse_i,
   input  logic zc_en_i,
   output logic pend_o,
   output lvl_t snap_o,
   output logic zc_flag_o
);
   logic pend_q;
   lvl_t snap_q;
   logic zc_flag_q;
   logic trig;

   assign trig = !pend_q && ((|((live_i ^ snap_q) & en_lvl_i)) || zc_flag_q);

   // snapshot follows the live levels until an interrupt is pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q <= '0;
      else if (!pend_q) snap_q <= live_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pend_q <= 1'b0;
      else if (chan_rst_i || clr_i)  pend_q <= 1'b0;
      else if (trig)                 pend_q <= 1'b1;
   end

   // zero-count event flag: a new pulse wins over the reset command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      zc_flag_q <= 1'b0;
      else if (chan_rst_i)             zc_flag_q <= 1'b0;
      else if (zc_pulse_i && zc_en_i)  zc_flag_q <= 1'b1;
      else if (clr_i)                  zc_flag_q <= 1'b0;
   end

   assign pend_o    = pend_q;
   assign snap_o    = snap_q;
   assign zc_flag_o = zc_flag_q;

   AST_RAISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past((|((live_i ^ snap_q) & en_lvl_i)) || zc_flag_q)); // R6
   AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> $stable(snap_q)); // R7
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i || chan_rst_i) |=> !pend_q); // R8
   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr_i && !chan_rst_i) |=> pend_q); // R8
   AST_ZC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_pulse_i && zc_en_i && !chan_rst_i) |=> zc_flag_q); // R9
endmodule

// File: rtl/extstat_irq.sv
module extstat_irq
   import esi_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chan_rst_i,
   input  logic       wr_en_i,
   input  logic [7:0] wr_data_i,
   output logic [7:0] en_o,
   input  logic       brk_abort_i,
   input  logic       tx_undr_i,
   input  logic       hunt_i,
   input  logic       cts_pin_i,
   input  logic       dcd_pin_i,
   input  logic       sync_pin_i,
   input  logic       zcount_i,
   input  logic       async_mode_i,
   input  logic       sdlc_mode_i,
   input  logic       es_reset_i,
   input  logic       tx_empty_i,
   input  logic       rx_avail_i,
   output logic [7:0] status_o,
   output logic       irq_o,
   output logic       fifo_en_o,
   output logic       alt_wr_o
);
   localparam int NPIN = 3;

   en_t             en_q;
   logic [NPIN-1:0] pins_raw, pins_s;
   logic            cts_s, dcd_s, sync_s, sh_lvl;
   lvl_t            live, snap;
   logic            pend, zc_flag;

   esi_enreg i_enreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_rst_i (chan_rst_i),
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .en_q       (en_q)
   );

   assign pins_raw = {cts_pin_i, dcd_pin_i, sync_pin_i};

   esi_sync #(.STAGES(SYNC_STAGES), .W(NPIN)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   assign {cts_s, dcd_s, sync_s} = pins_s;
   assign sh_lvl = async_mode_i ? sync_s : hunt_i;
   assign live   = {brk_abort_i, tx_undr_i, cts_s, sh_lvl, dcd_s};

   esi_detect i_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_rst_i (chan_rst_i),
      .clr_i      (es_reset_i),
      .live_i     (live),
      .en_lvl_i   (en_q[B_BRK:LVL_LO]),
      .zc_pulse_i (zcount_i),
      .zc_en_i    (en_q[B_ZC]),
      .pend_o     (pend),
      .snap_o     (snap),
      .zc_flag_o  (zc_flag)
   );

   always_comb begin
      status_o               = '0;
      status_o[B_BRK:LVL_LO] = pend ? snap : live;
      status_o[B_FIFO]       = tx_empty_i;
      status_o[B_ZC]         = zc_flag;
      status_o[B_ALT]        = rx_avail_i;
   end

   assign en_o      = en_q;
   assign irq_o     = pend;
   assign fifo_en_o = en_q[B_FIFO] & sdlc_mode_i;
   assign alt_wr_o  = en_q[B_ALT];

   AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $past(irq_o)) |-> $stable(status_o[B_BRK:LVL_LO])); // R7
endmodule

// File: tb/test_extstat_irq.sv
module test_extstat_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_rst_i = 1'b0, wr_en_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] en_o, status_o;
   logic       brk_abort_i = 0, tx_undr_i = 0, hunt_i = 0;
   logic       cts_pin_i = 0, dcd_pin_i = 0, sync_pin_i = 0, zcount_i = 0;
   logic       async_mode_i = 1, sdlc_mode_i = 0, es_reset_i = 0;
   logic       tx_empty_i = 0, rx_avail_i = 0;
   logic       irq_o, fifo_en_o, alt_wr_o;
   int         nchk = 0, nfail = 0;
   bit         done = 0;

   always #4 clk = ~clk;

   extstat_irq i_extstat_irq (
      .clk(clk), .rst_n(rst_n), .chan_rst_i(chan_rst_i), .wr_en_i(wr_en_i),
      .wr_data_i(wr_data_i), .en_o(en_o), .brk_abort_i(brk_abort_i),
      .tx_undr_i(tx_undr_i), .hunt_i(hunt_i), .cts_pin_i(cts_pin_i),
      .dcd_pin_i(dcd_pin_i), .sync_pin_i(sync_pin_i), .zcount_i(zcount_i),
      .async_mode_i(async_mode_i), .sdlc_mode_i(sdlc_mode_i),
      .es_reset_i(es_reset_i), .tx_empty_i(tx_empty_i), .rx_avail_i(rx_avail_i),
      .status_o(status_o), .irq_o(irq_o), .fifo_en_o(fifo_en_o), .alt_wr_o(alt_wr_o)
   );

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] v);
      wr_en_i = 1; wr_data_i = v; tick(1); wr_en_i = 0;
   endtask

   task automatic pulse_es();
      es_reset_i = 1; tick(1); es_reset_i = 0;
   endtask

   task automatic set_src(int i, logic v);
      case (i)
         0: brk_abort_i = v;
         1: tx_undr_i   = v;
         2: cts_pin_i   = v;
         3: sync_pin_i  = v;
         default: dcd_pin_i = v;
      endcase
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      // R1 reset state
      chk("R1 en", en_o, 8'hF8);
      chk("R1 irq", {7'd0, irq_o}, 8'd0);
      chk("R1 status", status_o, 8'h00);

      // R2 exhaustive enable write/readback
      for (int v = 0; v < 256; v++) begin
         wr(v[7:0]);
         chk("R2 readback", en_o, v[7:0]);
      end

      // R11 flag sweep
      for (int c = 0; c < 8; c++) begin
         sdlc_mode_i = c[2];
         wr({5'd0, c[1], 1'b0, c[0]});
         chk("R11 fifo_en", {7'd0, fifo_en_o}, {7'd0, c[1] & c[2]});
         chk("R11 alt_wr", {7'd0, alt_wr_o}, {7'd0, c[0]});
      end
      sdlc_mode_i = 0;

      // R3 R4 R6 sweep over sources, enable and direction
      for (int i = 0; i < 5; i++) begin
         for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 2; d++) begin
               string tag;
               logic  v;
               v   = (d == 0);
               tag = (e == 0) ? "R6 disabled source" : (i < 2) ? "R3 direct source" : "R4 pin source";
               wr(e != 0 ? (8'h80 >> i) : 8'h00);
               set_src(i, v);
               tick(4);
               chk(tag, {7'd0, irq_o}, {7'd0, e[0]});
               chk({tag, " status"}, {7'd0, status_o[7-i]}, {7'd0, v});
               pulse_es();
               tick(1);
               chk({tag, " cleared"}, {7'd0, irq_o}, 8'd0);
            end
         end
      end

      // R3 exact one-edge latency for a direct source
      wr(8'h80);
      brk_abort_i = 1; tick(1);
      chk("R3 rise one edge", {7'd0, irq_o}, 8'd1);
      pulse_es();
      brk_abort_i = 0; tick(1);
      chk("R3 fall one edge", {7'd0, irq_o}, 8'd1);
      pulse_es();

      // R4 exact pin latency
      wr(8'h20);
      cts_pin_i = 1; tick(2);
      chk("R4 not after two", {7'd0, irq_o}, 8'd0);
      tick(1);
      chk("R4 after three", {7'd0, irq_o}, 8'd1);
      pulse_es();
      cts_pin_i = 0; tick(4); pulse_es(); tick(1);

      // R5 mode selection of bit 4 source
      wr(8'h10);
      hunt_i = 1; tick(4);
      chk("R5 hunt ignored async", {7'd0, irq_o}, 8'd0);
      hunt_i = 0; tick(4);
      async_mode_i = 0; tick(1);
      hunt_i = 1; tick(1);
      chk("R5 hunt sync mode", {7'd0, irq_o}, 8'd1);
      chk("R5 hunt status", {7'd0, status_o[4]}, 8'd1);
      pulse_es();
      sync_pin_i = 1; tick(4);
      chk("R5 sync pin ignored sync mode", {7'd0, irq_o}, 8'd0);
      sync_pin_i = 0; hunt_i = 0; tick(1);
      chk("R5 hunt fall", {7'd0, irq_o}, 8'd1);
      pulse_es(); tick(4);
      async_mode_i = 1; tick(1);
      chk("R5 quiet", {7'd0, irq_o}, 8'd0);

      // R7 R8 snapshot freeze and re-raise
      wr(8'h80);
      brk_abort_i = 1; tick(1);
      chk("R7 raised", {7'd0, irq_o}, 8'd1);
      cts_pin_i = 1; brk_abort_i = 0; tx_empty_i = 1; rx_avail_i = 1; tick(4);
      chk("R7 frozen status", status_o, 8'h85);
      chk("R8 held", {7'd0, irq_o}, 8'd1);
      tx_empty_i = 0; rx_avail_i = 0;
      pulse_es();
      chk("R8 cleared", {7'd0, irq_o}, 8'd0);
      tick(1);
      chk("R8 re-raised", {7'd0, irq_o}, 8'd1);
      chk("R8 new snapshot", status_o, 8'h20);
      pulse_es(); tick(1);
      chk("R8 stays low", {7'd0, irq_o}, 8'd0);
      cts_pin_i = 0; tick(4);

      // R9 zero count
      wr(8'h02);
      zcount_i = 1; tick(1); zcount_i = 0;
      chk("R9 flag", {7'd0, status_o[1]}, 8'd1);
      chk("R9 irq not yet", {7'd0, irq_o}, 8'd0);
      tick(1);
      chk("R9 irq", {7'd0, irq_o}, 8'd1);
      pulse_es(); tick(2);
      chk("R9 cleared irq", {7'd0, irq_o}, 8'd0);
      chk("R9 cleared flag", {7'd0, status_o[1]}, 8'd0);
      wr(8'h00);
      zcount_i = 1; tick(1); zcount_i = 0; tick(2);
      chk("R9 disabled irq", {7'd0, irq_o}, 8'd0);
      chk("R9 disabled flag", {7'd0, status_o[1]}, 8'd0);

      // R10 channel reset
      wr(8'h02);
      zcount_i = 1; tick(1); zcount_i = 0; tick(1);
      chk("R10 pre irq", {7'd0, irq_o}, 8'd1);
      chan_rst_i = 1; wr_en_i = 1; wr_data_i = 8'h00; tick(1);
      chan_rst_i = 0; wr_en_i = 0;
      chk("R10 defaults", en_o, 8'hF8);
      chk("R10 irq cleared", {7'd0, irq_o}, 8'd0);
      chk("R10 zc cleared", {7'd0, status_o[1]}, 8'd0);
      tick(2);
      chk("R10 quiet", {7'd0, irq_o}, 8'd0);
      tx_undr_i = 1; tick(1);
      chk("R10 default enable active", {7'd0, irq_o}, 8'd1);
      pulse_es();
      tx_undr_i = 0; tick(1); pulse_es();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule